// File: doc/BRIEF.md
# Configuration Unlock Port

This block is a byte-wide index/data register pair of the kind a legacy I/O controller uses for its configuration space. After reset the pair is locked. Software opens it by writing a four-byte key to the index port, selects a configuration register by writing its number to the index port, and then reads or writes that register through the data port. A write to the lock register closes the pair again. The host side is a simple strobe bus. A single address bit chooses between the index port and the data port.

The configuration space holds four things. There is a read-only 16-bit chip identifier. There is a logical-device select byte. There is a global flash-decode byte, which carries a suspend flag, three flash window enables, a host write enable and a pin-assignment select. Finally there is a two-byte base address for the serial flash controller, which is visible only while the flash logical device is selected.

A strap input is sampled during reset. It chooses between the primary port location (0x2E) and the alternate location (0x4E). The last key byte depends on that choice. The decoded values are brought out as plain outputs for the rest of the chip.

Top module: `cfg_unlock_port`

## Requirements
- R1: After reset the port is locked, the index is 0x00, the device select is 0x00, `flash_decode` is 0x00 and `spi_base` equals the parameter `SPI_BASE_RST` (default 0x0820).
- R2: With the strap low during reset, `cfg_base` is 0x2E. Writing 0x87, 0x01, 0x55, 0x55 to the index port (`addr_sel`=0) unlocks the port, and `unlocked` is high after the clock edge that takes the last byte.
- R3: With the strap high during reset, `cfg_base` is 0x4E and the key is 0x87, 0x01, 0x55, 0xAA. In this mode a final byte of 0x55 does not unlock the port. In primary mode a final byte of 0xAA does not unlock it.
- R4: An index write that does not match the next expected key byte restarts detection. If that write is 0x87, it counts as the first key byte.
- R5: While the port is locked, reads of either port return 0xFF. Data-port writes are ignored, and index-port writes do not change the index.
- R6: While the port is unlocked, an index write selects the register, and an index read returns the current index.
- R7: Registers 0x20 and 0x21 return the high and low bytes of the parameter `CHIP_ID` (default 0x8716). Writes to them are ignored.
- R8: Register 0x07 is the read/write device select. Registers 0x64 (high byte) and 0x65 (low byte) hold `spi_base` only while the device select equals 7. For any other device select they read 0x00 and ignore writes.
- R9: In register 0x24, bits 5:0 are writable and appear on `flash_decode`. Bits 7:6 read as 0.
- R10: A data write to register 0x02 with bit 1 set locks the port. A write with bit 1 clear has no effect. Register 0x02 reads 0x00. After a lock, the full key is needed again.
- R11: The strap is sampled only while reset is active. Changing it later does not alter the key or `cfg_base`.
- R12: Unmapped registers read 0x00.
- R13: Read data appears on `rdata` after the clock edge that samples `rd_stb`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_base_strap | input | 1 | Port location strap, sampled during reset (1 = alternate) |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| addr_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| unlocked | output | 1 | Configuration space is open |
| cfg_base | output | 16 | I/O address at which the pair is decoded |
| spi_base | output | 16 | Serial flash controller base address |
| flash_decode | output | 6 | Flash decode and control bits |

## Verification
The key detector is exercised with several sequences:
- the clean key;
- a key broken by a foreign byte and then finished, which must stay locked because detection restarted;
- a key interrupted by 0x87, which must unlock because the interrupting byte starts a new key;
- the other mode's key, which must be rejected.

Register access is tried with the flash device deselected and then selected, which separates correct gating of the base-address pair from an always-visible pair. Lock and re-unlock, together with a strap change outside reset, show that the strap is held and that the detector starts from its first byte after a lock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int unsigned KEY_LEN = 4;
  localparam int unsigned KPW     = $clog2(KEY_LEN);

  localparam logic [7:0] REG_LOCK   = 8'h02;
  localparam logic [7:0] REG_DEVSEL = 8'h07;
  localparam logic [7:0] REG_ID_HI  = 8'h20;
  localparam logic [7:0] REG_ID_LO  = 8'h21;
  localparam logic [7:0] REG_DECODE = 8'h24;
  localparam logic [7:0] REG_BASE_H = 8'h64;
  localparam logic [7:0] REG_BASE_L = 8'h65;

  localparam logic [7:0] LOCKED_READ = 8'hFF;

  // expected key byte at a position, per port location
  function automatic logic [7:0] key_byte(input logic [KPW-1:0] pos, input logic alt);
    case (pos)
      2'd0:    key_byte = 8'h87;
      2'd1:    key_byte = 8'h01;
      2'd2:    key_byte = 8'h55;
      default: key_byte = alt ? 8'hAA : 8'h55;
    endcase
  endfunction

  function automatic logic [15:0] port_addr(input logic alt);
    port_addr = alt ? 16'h004E : 16'h002E;
  endfunction

endpackage

// File: rtl/cfg_key_detect.sv
module cfg_key_detect
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt,
  input  logic       kwr,
  input  logic [7:0] kdata,
  output logic       key_done
);

  logic [KPW-1:0] prog_q;
  logic [7:0]     exp_byte;
  logic [7:0]     first_byte;
  logic           hit;
  logic           at_last;

  assign exp_byte   = key_byte(prog_q, alt);
  assign first_byte = key_byte('0, alt);
  assign hit        = (kdata == exp_byte);
  assign at_last    = (prog_q == KPW'(KEY_LEN - 1));
  assign key_done   = kwr && hit && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q <= '0;
    end else if (kwr) begin
      if (hit) prog_q <= at_last ? '0 : prog_q + 1'b1;
      else     prog_q <= (kdata == first_byte) ? KPW'(1) : '0;
    end
  end

  // R4
  key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kwr && kdata != key_byte(prog_q, alt) && kdata != 8'h87) |=> prog_q == '0);

  // R4
  key_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kwr && prog_q != '0 && kdata == 8'h87 && kdata != key_byte(prog_q, alt)) |=> prog_q == KPW'(1));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID      = 16'h8716,
  parameter logic [15:0] SPI_BASE_RST = 16'h0820,
  parameter logic [7:0]  DEV_FLASH    = 8'h07,
  parameter int unsigned DEC_W        = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unlocked,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             addr_sel,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             lock_req,
  output logic [15:0]      spi_base,
  output logic [DEC_W-1:0] flash_decode
);

  logic [7:0]       idx_q;
  logic [7:0]       dev_q;
  logic [DEC_W-1:0] dec_q;
  logic [15:0]      base_q;
  logic [7:0]       rdata_q;
  logic [7:0]       rd_val;

  logic wr_idx, wr_dat, flash_sel;

  assign wr_idx    = wr_stb && !addr_sel && unlocked;
  assign wr_dat    = wr_stb &&  addr_sel && unlocked;
  assign flash_sel = (dev_q == DEV_FLASH);
  assign lock_req  = wr_dat && (idx_q == REG_LOCK) && wdata[1];

  always_comb begin
    rd_val = 8'h00;
    if (!unlocked)     rd_val = LOCKED_READ;
    else if (!addr_sel) rd_val = idx_q;
    else begin
      case (idx_q)
        REG_DEVSEL: rd_val = dev_q;
        REG_ID_HI:  rd_val = CHIP_ID[15:8];
        REG_ID_LO:  rd_val = CHIP_ID[7:0];
        REG_DECODE: rd_val = 8'(dec_q);
        REG_BASE_H: rd_val = flash_sel ? base_q[15:8] : 8'h00;
        REG_BASE_L: rd_val = flash_sel ? base_q[7:0]  : 8'h00;
        default:    rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 8'h00;
      dev_q   <= 8'h00;
      dec_q   <= '0;
      base_q  <= SPI_BASE_RST;
      rdata_q <= 8'h00;
    end else begin
      if (rd_stb) rdata_q <= rd_val;
      if (wr_idx) idx_q <= wdata;
      if (wr_dat) begin
        case (idx_q)
          REG_DEVSEL: dev_q <= wdata;
          REG_DECODE: dec_q <= wdata[DEC_W-1:0];
          REG_BASE_H: if (flash_sel) base_q[15:8] <= wdata;
          REG_BASE_L: if (flash_sel) base_q[7:0]  <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign rdata        = rdata_q;
  assign spi_base     = base_q;
  assign flash_decode = dec_q;

  // R8
  base_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr_sel && dev_q != DEV_FLASH) |=> $stable(spi_base));

  // R5
  locked_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !unlocked) |=> $stable({idx_q, dev_q, dec_q, base_q}));

  // R5
  locked_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !unlocked) |=> rdata == 8'hFF);

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rdata));

endmodule

// File: rtl/cfg_unlock_port.sv
module cfg_unlock_port
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID      = 16'h8716,
  parameter logic [15:0] SPI_BASE_RST = 16'h0820,
  parameter logic [7:0]  DEV_FLASH    = 8'h07,
  parameter int unsigned DEC_W        = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alt_base_strap,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             addr_sel,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             unlocked,
  output logic [15:0]      cfg_base,
  output logic [15:0]      spi_base,
  output logic [DEC_W-1:0] flash_decode
);

  logic alt_q;
  logic open_q;
  logic key_done;
  logic lock_req;
  logic key_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) alt_q <= alt_base_strap;
  end

  assign key_wr = wr_stb && !addr_sel && !open_q;

  cfg_key_detect u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .alt      (alt_q),
    .kwr      (key_wr),
    .kdata    (wdata),
    .key_done (key_done)
  );

  cfg_regfile #(
    .CHIP_ID      (CHIP_ID),
    .SPI_BASE_RST (SPI_BASE_RST),
    .DEV_FLASH    (DEV_FLASH),
    .DEC_W        (DEC_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .unlocked     (open_q),
    .wr_stb       (wr_stb),
    .rd_stb       (rd_stb),
    .addr_sel     (addr_sel),
    .wdata        (wdata),
    .rdata        (rdata),
    .lock_req     (lock_req),
    .spi_base     (spi_base),
    .flash_decode (flash_decode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        open_q <= 1'b0;
    else if (key_done) open_q <= 1'b1;
    else if (lock_req) open_q <= 1'b0;
  end

  assign unlocked = open_q;
  assign cfg_base = port_addr(alt_q);

  // R2
  unlock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(wr_stb && !addr_sel));

  // R10
  lock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> $past(wr_stb && addr_sel && wdata[1]));

  // R11
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cfg_base));

endmodule

// File: tb/sim_cfg_unlock_port.sv
module sim_cfg_unlock_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       wr_stb = 1'b0;
  logic       rd_stb = 1'b0;
  logic       addr_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       unlocked;
  logic [15:0] cfg_base;
  logic [15:0] spi_base;
  logic [5:0]  flash_decode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  cfg_unlock_port u0 (
    .clk(clk), .rst_n(rst_n), .alt_base_strap(strap),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .addr_sel(addr_sel), .wdata(wdata),
    .rdata(rdata), .unlocked(unlocked), .cfg_base(cfg_base),
    .spi_base(spi_base), .flash_decode(flash_decode)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; addr_sel = sel; wdata = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // driver: push expected value, issue the read
  task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_stb = 1'b1; addr_sel = sel;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic send_key(input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] b3);
    wr(1'b0, b0); wr(1'b0, b1); wr(1'b0, b2); wr(1'b0, b3);
  endtask

  task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
    wr(1'b0, r); wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] r, input logic [7:0] exp, input string tag);
    wr(1'b0, r); rd(1'b1, exp, tag);
  endtask

  // monitor: compare the registered read data one cycle after the strobe
  always @(posedge clk) begin
    if (rst_n && rd_stb) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R13: unexpected read, actual %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), {8'h00, rdata}, {8'h00, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    // R1 reset state
    check("R1 locked", {15'd0, unlocked}, 16'd0);
    check("R1 spi_base", spi_base, 16'h0820);
    check("R1 decode", {10'd0, flash_decode}, 16'd0);
    check("R2 cfg_base", cfg_base, 16'h002E);
    // R5 locked behaviour
    rd(1'b1, 8'hFF, "R5 data read locked");
    rd(1'b0, 8'hFF, "R5 index read locked");
    wr(1'b1, 8'h5A);
    check("R5 data write ignored", {15'd0, unlocked}, 16'd0);
    // R4 broken key must not unlock
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h33); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    check("R4 broken key", {15'd0, unlocked}, 16'd0);
    // R3 alternate key rejected in primary mode
    send_key(8'h87, 8'h01, 8'h55, 8'hAA);
    check("R3 other key", {15'd0, unlocked}, 16'd0);
    // R4 0x87 restart counts as first byte
    wr(1'b0, 8'h87); wr(1'b0, 8'h01);
    send_key(8'h87, 8'h01, 8'h55, 8'h55);
    check("R4 restart on 87", {15'd0, unlocked}, 16'd1);
    // R6 index unchanged by key writes, readable
    rd(1'b0, 8'h00, "R6 index after unlock");
    wr(1'b0, 8'h24);
    rd(1'b0, 8'h24, "R6 index readback");
    // R7 chip id
    reg_rd(8'h20, 8'h87, "R7 id high");
    reg_rd(8'h21, 8'h16, "R7 id low");
    wr(1'b1, 8'hAA);
    rd(1'b1, 8'h16, "R7 id write ignored");
    // R9 decode register
    reg_wr(8'h24, 8'hFF);
    rd(1'b1, 8'h3F, "R9 decode read");
    check("R9 decode out", {10'd0, flash_decode}, 16'h003F);
    // R8 base gated by device select
    reg_rd(8'h64, 8'h00, "R8 base hidden");
    wr(1'b1, 8'h12);
    check("R8 base unchanged", spi_base, 16'h0820);
    reg_wr(8'h07, 8'h07);
    rd(1'b1, 8'h07, "R8 devsel read");
    reg_wr(8'h64, 8'h12);
    reg_wr(8'h65, 8'h34);
    check("R8 base written", spi_base, 16'h1234);
    reg_rd(8'h64, 8'h12, "R8 base high read");
    // R12 unmapped
    reg_rd(8'h50, 8'h00, "R12 unmapped");
    // R10 lock register
    reg_rd(8'h02, 8'h00, "R10 lock reg read");
    wr(1'b1, 8'h00);
    check("R10 bit1 clear", {15'd0, unlocked}, 16'd1);
    wr(1'b1, 8'h02);
    check("R10 lock", {15'd0, unlocked}, 16'd0);
    rd(1'b1, 8'hFF, "R10 locked read");
    // R11 strap change outside reset
    strap = 1'b1;
    send_key(8'h87, 8'h01, 8'h55, 8'hAA);
    check("R11 strap ignored key", {15'd0, unlocked}, 16'd0);
    send_key(8'h87, 8'h01, 8'h55, 8'h55);
    check("R11 primary key still", {15'd0, unlocked}, 16'd1);
    check("R11 cfg_base held", cfg_base, 16'h002E);
    // R3 alternate mode
    do_reset(1'b1);
    @(negedge clk);
    check("R3 cfg_base alt", cfg_base, 16'h004E);
    check("R1 spi_base again", spi_base, 16'h0820);
    send_key(8'h87, 8'h01, 8'h55, 8'h55);
    check("R3 primary key rejected", {15'd0, unlocked}, 16'd0);
    send_key(8'h87, 8'h01, 8'h55, 8'hAA);
    check("R3 alt key", {15'd0, unlocked}, 16'd1);
    repeat (4) @(negedge clk);
    check("R13 reads drained", 16'(exp_q.size()), 16'd0);
    finish_run();
  end

endmodule